// File: doc/BRIEF.md
# At-Speed Scan Capture Clock Controller

This block drives the scan flops of one clock domain, placing itself after that domain's PLL tap or divider. In normal operation it passes the functional clock unchanged. Under test, while scan enable is high it hands the domain the slow tester clock for shifting. When scan enable falls it arms a capture burst that delivers a fixed number of functional-speed pulses, two by default: one launch and one capture, as transition-delay test needs.

Each domain has its own instance. A shared start input lets controllers on related domains (for example a full-rate branch and its divide-by-2 and divide-by-4 branches) hold their bursts until a common go signal arrives, so that paths crossing between domains are launched and captured at speed. Both clock paths are gated by enables that latches take only while the respective clock is low, and the two paths are never enabled together in test mode. A busy flag covers the interval from arming to the end of the burst.

Top module: `atspeed_clk_ctrl`

## Requirements
- R1: When `test_mode` is low, `dom_clk` follows `clk_fn` one pulse per cycle, `busy` stays low and `scan_en` has no effect.
- R2: When `test_mode` and `scan_en` are both high, every `clk_tst` pulse appears once on `dom_clk` and no `clk_fn` pulse reaches it; the functional and tester gate enables are never active together in test mode.
- R3: After `scan_en` falls in test mode and passes a 2-stage synchroniser clocked by `clk_fn`, and the synchronised start is high, `dom_clk` carries exactly PULSES (default 2) `clk_fn` pulses.
- R4: While the synchronised `sync_go` is low the armed controller emits no pulse; once it goes high the burst starts.
- R5: After the burst, `dom_clk` stays low until `scan_en` is raised again.
- R6: `busy` is low after reset and during shift; it is high from arming until the cycle after the last burst pulse, which with `sync_go` already high is PULSES+2 `clk_fn` cycles.
- R7: After `scan_en` rises again (synchronised), tester pulses reach `dom_clk` once more.
- R8: Lowering `test_mode` while armed abandons the capture: `busy` drops and functional pass-through resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fn | input | 1 | Functional clock from the PLL or divider |
| clk_tst | input | 1 | Slow tester clock used for shifting |
| rst | input | 1 | Synchronous active-high reset in the `clk_fn` domain |
| test_mode | input | 1 | Static test select; low gives functional pass-through |
| scan_en | input | 1 | High for shift, falling edge arms a capture |
| sync_go | input | 1 | Common start for aligning bursts across domains; tie high for a lone domain |
| dom_clk | output | 1 | Clock delivered to the domain's flops |
| busy | output | 1 | High from arming until the burst has ended |

## Verification
The capture path is driven with shift sequences of one to five tester pulses, each followed by a capture that either finds the start signal already high or waits several cycles for it; this separates a burst that honours the start gate from one that fires on the scan-enable edge alone, and a correct pulse count from one that stops short or runs on. Quiet windows after each burst and further shifts after scan enable returns tell a held-low clock and a restored tester path apart from a leaky gate. A cycle-by-cycle sample of the busy flag checks its exact length, and dropping test mode while armed checks that the capture is abandoned.

// File: rtl/ocg_pkg.sv
`timescale 1ns/1ps
package ocg_pkg;

    localparam int unsigned OCG_DEF_PULSES = 2;
    localparam int unsigned OCG_DEF_STAGES = 2;

    typedef enum logic [2:0] {
        PH_SHIFT = 3'd0,
        PH_ARMED = 3'd1,
        PH_BURST = 3'd2,
        PH_TAIL  = 3'd3,
        PH_HOLD  = 3'd4
    } phase_e;

    typedef struct packed {
        logic burst;
        logic tester;
    } gate_req_t;

    function automatic logic phase_busy(input phase_e p);
        return (p == PH_ARMED) || (p == PH_BURST) || (p == PH_TAIL);
    endfunction

endpackage

// File: rtl/ocg_sync.sv
`timescale 1ns/1ps
module ocg_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= RST_VAL;
        else     chain[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[g] <= RST_VAL;
            else     chain[g] <= chain[g-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ocg_gate.sv
`timescale 1ns/1ps
module ocg_gate (
    input  logic clk_in,
    input  logic en,
    output logic clk_out
);
    logic en_l;

    // Enable is taken only in the low phase, so the gated output never chops a high phase.
    always_latch begin
        if (!clk_in) en_l = en;
    end

    assign clk_out = clk_in & en_l;
endmodule

// File: rtl/ocg_seq.sv
`timescale 1ns/1ps
module ocg_seq
    import ocg_pkg::*;
#(
    parameter int unsigned PULSES = OCG_DEF_PULSES
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      test_mode,
    input  logic      scan_en,
    input  logic      se_s,
    input  logic      go_s,
    output gate_req_t req,
    output logic      busy
);
    localparam int unsigned CW = (PULSES > 1) ? $clog2(PULSES) : 1;
    localparam logic [CW-1:0] LAST = CW'(PULSES - 1);

    phase_e        ph, ph_n;
    logic [CW-1:0] cnt, cnt_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph  <= PH_SHIFT;
            cnt <= '0;
        end else begin
            ph  <= ph_n;
            cnt <= cnt_n;
        end
    end

    always_comb begin
        ph_n  = ph;
        cnt_n = cnt;
        if (!test_mode) begin
            ph_n  = PH_SHIFT;
            cnt_n = '0;
        end else begin
            unique case (ph)
                PH_SHIFT: if (!se_s) ph_n = PH_ARMED;
                PH_ARMED: begin
                    if (se_s) begin
                        ph_n = PH_SHIFT;
                    end else if (go_s) begin
                        ph_n  = PH_BURST;
                        cnt_n = '0;
                    end
                end
                PH_BURST: begin
                    if (cnt == LAST) ph_n = PH_TAIL;
                    else             cnt_n = cnt + 1'b1;
                end
                PH_TAIL:  ph_n = PH_HOLD;
                PH_HOLD:  if (se_s) ph_n = PH_SHIFT;
                default:  ph_n = PH_SHIFT;
            endcase
        end
    end

    assign req.burst  = (ph == PH_BURST);
    assign req.tester = test_mode & scan_en & (ph == PH_SHIFT);
    assign busy       = phase_busy(ph);
endmodule

// File: rtl/atspeed_clk_ctrl.sv
`timescale 1ns/1ps
module atspeed_clk_ctrl
    import ocg_pkg::*;
#(
    parameter int unsigned PULSES = OCG_DEF_PULSES,
    parameter int unsigned STAGES = OCG_DEF_STAGES
) (
    input  logic clk_fn,
    input  logic clk_tst,
    input  logic rst,
    input  logic test_mode,
    input  logic scan_en,
    input  logic sync_go,
    output logic dom_clk,
    output logic busy
);
    logic      se_s, go_s;
    gate_req_t req;
    logic      burst_en, tck_en, fn_en;
    logic      fn_gclk, tst_gclk;

    ocg_sync #(.STAGES(STAGES), .RST_VAL(1'b1)) u_se_sync (
        .clk(clk_fn), .rst(rst), .d(scan_en), .q(se_s)
    );

    ocg_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_go_sync (
        .clk(clk_fn), .rst(rst), .d(sync_go), .q(go_s)
    );

    ocg_seq #(.PULSES(PULSES)) u_seq (
        .clk(clk_fn), .rst(rst), .test_mode(test_mode), .scan_en(scan_en),
        .se_s(se_s), .go_s(go_s), .req(req), .busy(busy)
    );

    assign burst_en = req.burst;
    assign tck_en   = req.tester;
    assign fn_en    = ~test_mode | burst_en;

    ocg_gate u_fn_gate (.clk_in(clk_fn),  .en(fn_en),  .clk_out(fn_gclk));
    ocg_gate u_ts_gate (.clk_in(clk_tst), .en(tck_en), .clk_out(tst_gclk));

    assign dom_clk = fn_gclk | tst_gclk;
endmodule

// File: rtl/atspeed_clk_ctrl_chk.sv
`timescale 1ns/1ps
module atspeed_clk_ctrl_chk #(
    parameter int unsigned PULSES = 2
) (
    input logic clk,
    input logic rst,
    input logic test_mode,
    input logic busy,
    input logic burst_en,
    input logic tck_en,
    input logic go_s
);
    logic [7:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst)           run_cnt <= '0;
        else if (burst_en) run_cnt <= run_cnt + 8'd1;
        else               run_cnt <= '0;
    end

    p_passthru_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !test_mode |=> !busy);

    p_paths_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
        test_mode |-> !(burst_en && tck_en));

    p_burst_length_r3: assert property (@(posedge clk) disable iff (rst)
        ($fell(burst_en) && test_mode) |-> (run_cnt == 8'(PULSES)));

    p_start_gated_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(burst_en) |-> $past(go_s));

    p_quiet_when_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (test_mode && !busy) |-> !burst_en);

    p_busy_covers_burst_r6: assert property (@(posedge clk) disable iff (rst)
        burst_en |-> busy);
endmodule

bind atspeed_clk_ctrl atspeed_clk_ctrl_chk #(.PULSES(PULSES)) u_chk (
    .clk(clk_fn), .rst(rst), .test_mode(test_mode), .busy(busy),
    .burst_en(burst_en), .tck_en(tck_en), .go_s(go_s)
);

// File: tb/test_atspeed_clk_ctrl.sv
`timescale 1ns/1ps
module test_atspeed_clk_ctrl;
    logic clk_fn = 1'b0, clk_tst = 1'b0, rst = 1'b1;
    logic test_mode = 1'b0, scan_en = 1'b0, sync_go = 1'b0;
    logic dom_clk, busy;

    int n_chk = 0, n_fail = 0;
    int dom_cnt = 0;

    typedef struct packed {
        logic [7:0] go_delay;   // 0: start already high, else cycles before raising it
        logic [7:0] n_shift;    // tester pulses before the capture
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{8'd0,  8'd3},
        '{8'd6,  8'd5},
        '{8'd0,  8'd1},
        '{8'd10, 8'd4}
    };

    atspeed_clk_ctrl i_atspeed_clk_ctrl (
        .clk_fn(clk_fn), .clk_tst(clk_tst), .rst(rst), .test_mode(test_mode),
        .scan_en(scan_en), .sync_go(sync_go), .dom_clk(dom_clk), .busy(busy)
    );

    always #2.5 clk_fn = ~clk_fn;

    always @(posedge dom_clk) dom_cnt <= dom_cnt + 1;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk_fn);
    endtask

    task automatic pulse_tck();
        clk_tst = 1'b1; #20;
        clk_tst = 1'b0; #20;
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int base;
        int hi;
        cyc(4);
        check("R6 reset busy", int'(busy), 0);
        rst = 1'b0;
        cyc(3);

        // R1: functional pass-through, scan_en ignored
        base = dom_cnt; cyc(16);
        check("R1 pass-through", dom_cnt - base, 16);
        scan_en = 1'b1; cyc(3); scan_en = 1'b0;
        base = dom_cnt; cyc(16);
        check("R1 scan_en ignored", dom_cnt - base, 16);
        check("R1 busy low", int'(busy), 0);

        // enter test mode, shifting
        scan_en = 1'b1; test_mode = 1'b1;
        cyc(6);

        for (int i = 0; i < 4; i++) begin
            sync_go = (VECS[i].go_delay == 8'd0);
            cyc(4);
            base = dom_cnt;
            for (int k = 0; k < int'(VECS[i].n_shift); k++) pulse_tck();
            cyc(2);
            check((i == 0) ? "R2 shift" : "R2 R7 shift", dom_cnt - base, int'(VECS[i].n_shift));
            check("R6 busy in shift", int'(busy), 0);
            base = dom_cnt;
            scan_en = 1'b0;
            if (VECS[i].go_delay != 8'd0) begin
                cyc(int'(VECS[i].go_delay));
                check("R4 held", dom_cnt - base, 0);
                check("R6 busy armed", int'(busy), 1);
                sync_go = 1'b1;
            end
            cyc(12);
            check("R3 burst", dom_cnt - base, 2);
            check("R6 busy after", int'(busy), 0);
            base = dom_cnt; cyc(16);
            check("R5 held low", dom_cnt - base, 0);
            scan_en = 1'b1;
            cyc(5);
        end

        // R6: exact busy length with start already high
        hi = 0; base = dom_cnt;
        scan_en = 1'b0;
        for (int k = 0; k < 14; k++) begin
            cyc(1);
            if (busy) hi++;
        end
        check("R6 busy length", hi, 4);
        check("R3 burst directed", dom_cnt - base, 2);
        scan_en = 1'b1; cyc(5);
        base = dom_cnt; pulse_tck(); pulse_tck(); cyc(1);
        check("R7 restored", dom_cnt - base, 2);

        // R8: abandon while armed
        sync_go = 1'b0; cyc(4);
        scan_en = 1'b0; cyc(8);
        check("R8 armed busy", int'(busy), 1);
        test_mode = 1'b0; cyc(2);
        check("R8 busy cleared", int'(busy), 0);
        base = dom_cnt; cyc(10);
        check("R8 pass-through", dom_cnt - base, 10);

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule